// File: doc/BRIEF.md
# Differential Binary Phase Keying Codec

This block holds both halves of a bit-serial differential phase keying link. It runs on one system clock, and a bit-strobe input marks the cycles that start a new bit period, so the same clock can carry any bit rate. The transmit half turns each data bit into a line symbol. The line symbol is the select for a binary carrier phase: 1 picks the carrier as it is, and 0 picks the carrier inverted by 180 degrees. The receive half takes a symbol that an external slicer has already reduced to one bit. It recovers the data by comparing that symbol with the one latched at the strobe before.

The differential rule is XNOR. A symbol equal to the previous one means data 1, and a symbol that differs means data 0. The transmitter starts from a reference symbol, which can be 0 or 1. That reference is taken during reset either from the `ref_bit` pin or from a parameter. The receiver's two symbol registers reset to the same reference. When the transmit output is looped into the receive input, the data comes back exactly one strobe late.

Each half is a small state machine. The encoder has `ENC_HOLD_REF` and `ENC_RUN`. In `ENC_HOLD_REF` the reference is on the line and nothing has been sent yet. The first strobe moves it to `ENC_RUN`, where it stays until reset. The decoder has `DEC_EMPTY`, `DEC_REF` and `DEC_TRACK`. The first strobe moves it from `DEC_EMPTY` to `DEC_REF`, which means one symbol is latched. The second strobe moves it to `DEC_TRACK`, where the decoded bit is valid and stays valid until reset. Reset returns both machines to their first state.

Top module: `dpsk_codec`

## Requirements
- R1: While `rst` is high at a clock edge, `tx_sym` takes the reference value and `rx_valid` goes to 0.
- R2: With `USE_REF_PIN`=1 the reference is `ref_bit` as sampled during reset. With `USE_REF_PIN`=0 the reference is the `DEFAULT_REF` parameter, and `ref_bit` has no effect on it.
- R3: At each clock edge where `bit_en` is high, the new `tx_sym` is the XNOR of `tx_data` and the old `tx_sym`. A value of 1 selects the carrier as it is, and 0 selects the carrier inverted by 180 degrees.
- R4: On edges where `bit_en` is low, `tx_sym`, `rx_data` and `rx_valid` keep their values, whatever `tx_data` and `rx_sym` do.
- R5: At each edge where `bit_en` is high, the decoder latches `rx_sym`. When valid, `rx_data` is the XNOR of the symbol latched at the last strobe and the symbol latched at the strobe before it.
- R6: `rx_valid` is 0 after reset, stays 0 after the first strobe, and goes to 1 at the second strobe after reset.
- R7: With `rx_sym` tied to `tx_sym`, `rx_data` after strobe k equals the `tx_data` sampled at strobe k-1, for k of 2 or more and for either reference value.
- R8: When `rst` and `bit_en` are high at the same edge, reset wins: `tx_sym` becomes the reference and is not encoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-period strobe, one cycle per bit |
| ref_bit | input | 1 | Reference symbol, sampled while in reset (pin mode) |
| tx_data | input | 1 | Data bit to encode |
| tx_sym | output | 1 | Encoded symbol and carrier phase select (1 = 0 degrees, 0 = 180 degrees) |
| rx_sym | input | 1 | Hard-sliced received symbol |
| rx_data | output | 1 | Recovered data bit |
| rx_valid | output | 1 | Recovered data is meaningful |

## Verification
Two events can land on the same edge. The first pair is the encoder update and the decoder latch. In loopback, a strobe must latch the old `tx_sym` into the receiver while the encoder replaces it. Back-to-back strobes provoke this, and it is judged by comparing `rx_data` with the queued data one strobe behind. The second pair is reset and strobe. The bench raises `rst` and `bit_en` together with `tx_data` at 0, and then expects the reference on `tx_sym` rather than its inverse.

// File: rtl/dpsk_pkg.sv
package dpsk_pkg;

    typedef enum logic {
        ENC_HOLD_REF = 1'b0,
        ENC_RUN      = 1'b1
    } enc_state_t;

    typedef enum logic [1:0] {
        DEC_EMPTY = 2'd0,
        DEC_REF   = 2'd1,
        DEC_TRACK = 2'd2
    } dec_state_t;

    function automatic logic diff_rule(input logic a, input logic b);
        return ~(a ^ b);
    endfunction

endpackage

// File: rtl/dpsk_ref_sel.sv
module dpsk_ref_sel #(
    parameter bit USE_REF_PIN = 1'b1,
    parameter bit DEFAULT_REF = 1'b1
) (
    input  logic ref_pin,
    output logic ref_val
);
    generate
        if (USE_REF_PIN) begin : g_pin
            assign ref_val = ref_pin;
        end else begin : g_fixed
            logic unused_ref_pin;
            assign unused_ref_pin = ref_pin;
            assign ref_val        = DEFAULT_REF;
        end
    endgenerate
endmodule

// File: rtl/dpsk_diff_enc.sv
module dpsk_diff_enc
    import dpsk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic ref_val,
    input  logic data_in,
    output logic sym_out
);
    enc_state_t state_q;
    logic       ref_q;
    logic       sym_q;
    logic       sym_next;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENC_HOLD_REF;
        end else if (bit_en) begin
            unique case (state_q)
                ENC_HOLD_REF: state_q <= ENC_RUN;
                ENC_RUN:      state_q <= ENC_RUN;
            endcase
        end
    end

    // next symbol: first bit is coded against the held reference
    always_comb begin
        unique case (state_q)
            ENC_HOLD_REF: sym_next = diff_rule(data_in, ref_q);
            ENC_RUN:      sym_next = diff_rule(data_in, sym_q);
        endcase
    end

    // output registers (one-bit delay element)
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= ref_val;
            sym_q <= ref_val;
        end else if (bit_en) begin
            sym_q <= sym_next;
        end
    end

    assign sym_out = sym_q;
endmodule

// File: rtl/dpsk_diff_dec.sv
module dpsk_diff_dec
    import dpsk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic ref_val,
    input  logic sym_in,
    output logic data_out,
    output logic data_valid
);
    dec_state_t state_q;
    logic       lat_q;
    logic       dly_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DEC_EMPTY;
        end else if (bit_en) begin
            unique case (state_q)
                DEC_EMPTY: state_q <= DEC_REF;
                DEC_REF:   state_q <= DEC_TRACK;
                DEC_TRACK: state_q <= DEC_TRACK;
                default:   state_q <= DEC_EMPTY;
            endcase
        end
    end

    // slicer latch and one-bit delay
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= ref_val;
            dly_q <= ref_val;
        end else if (bit_en) begin
            lat_q <= sym_in;
            dly_q <= lat_q;
        end
    end

    // outputs
    always_comb begin
        data_out = diff_rule(lat_q, dly_q);
        unique case (state_q)
            DEC_TRACK: data_valid = 1'b1;
            default:   data_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/dpsk_codec.sv
module dpsk_codec #(
    parameter bit USE_REF_PIN = 1'b1,
    parameter bit DEFAULT_REF = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic ref_bit,
    input  logic tx_data,
    output logic tx_sym,
    input  logic rx_sym,
    output logic rx_data,
    output logic rx_valid
);
    logic ref_val;

    dpsk_ref_sel #(
        .USE_REF_PIN(USE_REF_PIN),
        .DEFAULT_REF(DEFAULT_REF)
    ) u_ref (
        .ref_pin(ref_bit),
        .ref_val(ref_val)
    );

    dpsk_diff_enc u_enc (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .ref_val(ref_val),
        .data_in(tx_data),
        .sym_out(tx_sym)
    );

    dpsk_diff_dec u_dec (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .ref_val   (ref_val),
        .sym_in    (rx_sym),
        .data_out  (rx_data),
        .data_valid(rx_valid)
    );
endmodule

// File: rtl/dpsk_codec_chk.sv
module dpsk_codec_chk #(
    parameter bit USE_REF_PIN = 1'b1,
    parameter bit DEFAULT_REF = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic ref_bit,
    input logic tx_data,
    input logic tx_sym,
    input logic rx_sym,
    input logic rx_data,
    input logic rx_valid
);
    logic h_new, h_old;
    logic [1:0] stb_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_new   <= 1'b0;
            h_old   <= 1'b0;
            stb_cnt <= 2'd0;
        end else if (bit_en) begin
            h_new <= rx_sym;
            h_old <= h_new;
            if (stb_cnt != 2'd3) stb_cnt <= stb_cnt + 2'd1;
        end
    end

    // R1 R2
    reset_ref_chk: assert property (@(posedge clk)
        rst |=> (tx_sym == (USE_REF_PIN ? $past(ref_bit) : DEFAULT_REF)) && !rx_valid);

    // R3
    encode_rule_chk: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> tx_sym == ~($past(tx_data) ^ $past(tx_sym)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(tx_sym) && $stable(rx_data) && $stable(rx_valid));

    // R5
    decode_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && stb_cnt >= 2'd2) |-> rx_data == ~(h_new ^ h_old));

    // R6
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> $past(bit_en) && stb_cnt >= 2'd2);
endmodule

bind dpsk_codec dpsk_codec_chk #(
    .USE_REF_PIN(USE_REF_PIN),
    .DEFAULT_REF(DEFAULT_REF)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .ref_bit (ref_bit),
    .tx_data (tx_data),
    .tx_sym  (tx_sym),
    .rx_sym  (rx_sym),
    .rx_data (rx_data),
    .rx_valid(rx_valid)
);

// File: tb/dpsk_codec_tb.sv
module dpsk_codec_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1, bit_en = 1'b0, ref_bit = 1'b1, tx_data = 1'b0;
    logic rx_drv = 1'b0, loop = 1'b1;
    logic tx_sym, rx_sym, rx_data, rx_valid;
    logic fix_tx, fix_rx_data, fix_rx_valid;

    assign rx_sym = loop ? tx_sym : rx_drv;

    dpsk_codec u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .ref_bit(ref_bit),
        .tx_data(tx_data), .tx_sym(tx_sym), .rx_sym(rx_sym),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    dpsk_codec #(.USE_REF_PIN(1'b0), .DEFAULT_REF(1'b0)) u_fix (
        .clk(clk), .rst(rst), .bit_en(bit_en), .ref_bit(ref_bit),
        .tx_data(tx_data), .tx_sym(fix_tx), .rx_sym(fix_tx),
        .rx_data(fix_rx_data), .rx_valid(fix_rx_valid)
    );

    int n_chk = 0, n_fail = 0;
    logic q[$];

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // capture what the design saw at each edge
    logic stb_q = 1'b0, rst_q = 1'b1, d_q = 1'b0, s_q = 1'b0;
    always @(posedge clk) begin
        stb_q <= bit_en && !rst;
        rst_q <= rst;
        d_q   <= tx_data;
        s_q   <= rx_sym;
    end

    // monitor / scoreboard
    int   cnt = 0;
    logic exp_enc = 1'b1, prev_s = 1'b0, last_tx = 1'b0, last_rx = 1'b0, last_v = 1'b0;
    always @(negedge clk) begin
        if (rst_q) begin
            cnt     = 0;
            exp_enc = ref_bit;
        end else if (stb_q) begin
            cnt++;
            exp_enc = ~(d_q ^ exp_enc);
            check("R3 encode", tx_sym, exp_enc);
            if (cnt == 1) check("R6 valid low after first strobe", rx_valid, 1'b0);
            if (cnt >= 2) check("R6 valid high", rx_valid, 1'b1);
            if (loop) begin
                if (cnt >= 2 && q.size() > 0) check("R7 loopback", rx_data, q.pop_front());
            end else begin
                if (cnt >= 2) check("R5 decode", rx_data, ~(s_q ^ prev_s));
                prev_s = s_q;
            end
        end else begin
            check("R4 hold tx", tx_sym, last_tx);
            check("R4 hold rx", rx_data, last_rx);
            check("R4 hold valid", rx_valid, last_v);
        end
        last_tx = tx_sym;
        last_rx = rx_data;
        last_v  = rx_valid;
    end

    task automatic do_reset(input logic r);
        rst = 1'b1; ref_bit = r; bit_en = 1'b0; q.delete();
        repeat (2) @(negedge clk);
        check("R1 reset symbol", tx_sym, r);
        check("R1 reset valid", rx_valid, 1'b0);
        check("R2 parameter reference", fix_tx, 1'b0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input logic d, input int gap);
        tx_data = d; bit_en = 1'b1;
        if (loop) q.push_back(d);
        @(negedge clk);
        if (gap > 0) begin
            bit_en = 1'b0;
            for (int i = 0; i < gap; i++) begin
                tx_data = 1'($urandom);
                rx_drv  = 1'($urandom);
                @(negedge clk);
            end
        end
    endtask

    task automatic send_sym(input logic s, input int gap);
        rx_drv = s;
        send(1'($urandom), gap);
    endtask

    task automatic reset_vs_strobe(input logic r);
        rst = 1'b1; ref_bit = r; bit_en = 1'b1; tx_data = 1'b0;
        @(negedge clk);
        check("R8 reset wins", tx_sym, r);
        bit_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int rv = 1; rv >= 0; rv--) begin
            loop = 1'b1;
            do_reset(1'(rv));
            for (int i = 0; i < 60; i++) send(1'($urandom), $urandom_range(0, 2));
            for (int i = 0; i < 8; i++) send(1'b1, 0);
            for (int i = 0; i < 8; i++) send(1'(i), 0);
            for (int i = 0; i < 6; i++) send(1'b0, 1);
            bit_en = 1'b0;
            repeat (3) @(negedge clk);
        end
        loop = 1'b0;
        do_reset(1'b1);
        for (int i = 0; i < 30; i++) send_sym(1'($urandom), $urandom_range(0, 2));
        send_sym(1'b0, 0); send_sym(1'b0, 0); send_sym(1'b1, 1);
        bit_en = 1'b0;
        @(negedge clk);
        loop = 1'b1;
        reset_vs_strobe(1'b1);
        reset_vs_strobe(1'b0);
        summary();
        $finish;
    end
endmodule